// File: doc/BRIEF.md
# Pipelined Radix-4 Booth Multiplier

This block multiplies two signed two's complement operands of width N (even, default 6) and returns the full 2N-bit signed product. It is a straight pipeline with one stage per radix-4 Booth digit of the multiplier, followed by one resolution stage. A new operand pair can be accepted on every clock, and each result appears a fixed number of cycles later with its own valid strobe.

No stage ever negates the multiplicand with a carry chain. A stage only selects, shifts or inverts the multiplicand. The +1 or +2 that completes a negative partial product travels to the next stage as a 2-bit code. That stage places the code in the two free bit positions just below its own shifted partial product, so a single row of full adders absorbs it. Before the code is used, the sum and carry bits one position lower are resolved into a final product bit. Their AND is added into the code, and the result can never leave the 2-bit field. A carry-save pair is kept throughout, and only the last stage carries out one carry-propagate addition.

Top module: `booth4_pipe_mult`

## Requirements
- R1: For every operand pair accepted with `in_valid` high, `out_product` equals the exact signed product of `in_a` (multiplicand) and `in_b` (multiplier), written as a 2N-bit two's complement value.
- R2: The product is exact when either operand, or both, is the most negative N-bit value; for N = 6, (-32)*(-32) gives +1024.
- R3: A result appears with `out_valid` high exactly N/2 + 1 rising edges after the edge that captured its operands: the edge that samples the inputs is counted, and the output is visible just after the last counted edge.
- R4: Operand pairs presented on consecutive cycles produce results on consecutive cycles, in the same order.
- R5: A synchronous active-high `rst` clears every valid bit. `out_valid` is low from the edge after `rst` is sampled high, and operands that were in flight when reset arrived never produce a result.
- R6: Each 3-bit multiplier group {b[2i+1], b[2i], b[2i-1]} with b[-1] = 0 selects a digit: 000 and 111 give 0; 001 and 010 give +1; 011 gives +2; 100 gives -2; 101 and 110 give -1. Negative digits use the inverted multiplicand, or the inverted and left-shifted multiplicand, and they set the forwarded correction code to 01 for -1 and 10 for -2. The code is 00 for the other digits, so a stored code is never 11.
- R7: Cycles with `in_valid` low produce no result, and the value on the operand inputs in those cycles has no effect on later results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid bits |
| in_valid | input | 1 | Operand pair on `in_a`/`in_b` is valid this cycle |
| in_a | input | N | Signed multiplicand |
| in_b | input | N | Signed multiplier, Booth recoded |
| out_valid | output | 1 | `out_product` holds a result this cycle |
| out_product | output | 2N | Signed product |

## Verification
The bench applies all 4096 operand pairs for N = 6 back to back, so every Booth group pattern meets every multiplicand. It also directs pairs built from the most negative value and multipliers made of -2 digits. A design that mixes up the +1 and +2 corrections, adds a code at the wrong weight, or loses the AND carry of the resolved bit would give products off by a power of two for exactly these patterns. Results are matched against a queue tagged with the cycle they are due, so an extra or missing pipeline register shows up as a latency error. Valid gaps with junk on the operand pins, and a reset during traffic, catch results that appear from nothing or survive the flush.

// File: rtl/booth4_pipe_mult.sv
module booth4_pipe_mult #(
  parameter int N = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [N-1:0]     in_a,
  input  logic [N-1:0]     in_b,
  output logic             out_valid,
  output logic [2*N-1:0]   out_product
);
  localparam int S    = N / 2;
  localparam int W    = 2 * N;
  localparam int RIDX = (N >= 4) ? N - 3 : 0;

  logic             v_q  [S];
  logic [N-1:0]     x_q  [S];
  logic [N-1:0]     y_q  [S];
  logic [W-1:0]     s_q  [S];
  logic [W-1:0]     c_q  [S];
  logic [S-1:0][1:0] code_q;

  logic             v_d  [S];
  logic [N-1:0]     x_d  [S];
  logic [N-1:0]     y_d  [S];
  logic [W-1:0]     s_d  [S];
  logic [W-1:0]     c_d  [S];
  logic [S-1:0][1:0] code_d;
  logic [W-1:0]     prod_d;

  function automatic logic [W-1:0] pp_of(input logic [N-1:0] a, input logic [2:0] g);
    logic [W-1:0] ax;
    ax = {{N{a[N-1]}}, a};
    case (g)
      3'b001, 3'b010: pp_of = ax;
      3'b011:         pp_of = ax << 1;
      3'b100:         pp_of = (~ax) << 1;
      3'b101, 3'b110: pp_of = ~ax;
      default:        pp_of = '0;
    endcase
  endfunction

  function automatic logic [1:0] code_of(input logic [2:0] g);
    case (g)
      3'b100:         code_of = 2'b10;
      3'b101, 3'b110: code_of = 2'b01;
      default:        code_of = 2'b00;
    endcase
  endfunction

  always_comb begin
    logic [W-1:0] s, c, op;
    logic [1:0]   k;
    logic         a_bit;
    int           p;
    v_d[0]    = in_valid;
    x_d[0]    = in_a;
    y_d[0]    = in_b >> 1;
    s_d[0]    = pp_of(in_a, {in_b[1:0], 1'b0});
    c_d[0]    = '0;
    code_d[0] = code_of({in_b[1:0], 1'b0});
    for (int i = 1; i < S; i++) begin
      p = 2 * i - 2;
      s = s_q[i-1];
      c = c_q[i-1];
      k = code_q[i-1];
      if (i >= 2) begin
        a_bit    = s[p-1] & c[p-1];
        s[p-1]   = s[p-1] ^ c[p-1];
        c[p-1]   = 1'b0;
        k        = k + {1'b0, a_bit};
      end
      op        = (pp_of(x_q[i-1], y_q[i-1][2:0]) << (2 * i)) | (W'(k) << p);
      s_d[i]    = s ^ c ^ op;
      c_d[i]    = ((s & c) | (s & op) | (c & op)) << 1;
      code_d[i] = code_of(y_q[i-1][2:0]);
      v_d[i]    = v_q[i-1];
      x_d[i]    = x_q[i-1];
      y_d[i]    = y_q[i-1] >> 2;
    end
  end

  always_comb begin
    logic [W-1:0] s, c;
    logic [1:0]   k;
    logic         a_bit;
    s = s_q[S-1];
    c = c_q[S-1];
    k = code_q[S-1];
    if (S >= 2) begin
      a_bit     = s[RIDX] & c[RIDX];
      s[RIDX]   = s[RIDX] ^ c[RIDX];
      c[RIDX]   = 1'b0;
      k         = k + {1'b0, a_bit};
    end
    prod_d = s + c + (W'(k) << (2 * S - 2));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < S; i++) v_q[i] <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      v_q       <= v_d;
      out_valid <= v_q[S-1];
    end
  end

  always_ff @(posedge clk) begin
    x_q         <= x_d;
    y_q         <= y_d;
    s_q         <= s_d;
    c_q         <= c_d;
    code_q      <= code_d;
    out_product <= prod_d;
  end
endmodule

// File: rtl/booth4_pipe_mult_chk.sv
module booth4_pipe_mult_chk #(
  parameter int N = 6
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic [N-1:0]          in_a,
  input logic [N-1:0]          in_b,
  input logic                  out_valid,
  input logic [2*N-1:0]        out_product,
  input logic [N/2-1:0][1:0]   code_q
);
  localparam int S = N / 2;
  localparam int W = 2 * N;

  logic [S:0]   vpipe;
  logic [W-1:0] ppipe [S+1];
  logic         rst_d = 1'b0;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) vpipe <= '0;
    else     vpipe <= {vpipe[S-1:0], in_valid};
    ppipe[0] <= W'($signed({{N{in_a[N-1]}}, in_a}) * $signed({{N{in_b[N-1]}}, in_b}));
    for (int i = 1; i <= S; i++) ppipe[i] <= ppipe[i-1];
  end

  // R3 R4 R7
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid == vpipe[S]);

  // R1 R2
  product_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_product == ppipe[S]);

  // R5
  always @(posedge clk) begin
    if (rst_d) flush_chk: assert (!out_valid);
  end

  // R6
  generate
    for (genvar j = 0; j < S; j++) begin : g_code
      code_range_chk: assert property (@(posedge clk) disable iff (rst)
        code_q[j] != 2'b11);
    end
  endgenerate
endmodule

bind booth4_pipe_mult booth4_pipe_mult_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
  .out_valid(out_valid), .out_product(out_product), .code_q(code_q)
);

// File: tb/booth4_pipe_mult_tb.sv
module booth4_pipe_mult_tb;
  localparam int N = 6;
  localparam int S = N / 2;
  localparam int W = 2 * N;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [N-1:0] in_a = '0;
  logic [N-1:0] in_b = '0;
  logic         out_valid;
  logic [W-1:0] out_product;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [W-1:0] q_prod [$];
  int           q_due  [$];
  string        q_tag  [$];

  booth4_pipe_mult #(.N(N)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_product(out_product)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic drive(input logic [N-1:0] a, input logic [N-1:0] b, input string tag);
    logic signed [N-1:0] sa, sb;
    int ai, bi;
    @(negedge clk);
    sa = a; sb = b;
    ai = int'(sa); bi = int'(sb);
    in_valid = 1'b1; in_a = a; in_b = b;
    q_prod.push_back(W'(ai * bi));
    q_due.push_back(cyc + 1 + S);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input logic [N-1:0] junk);
    @(negedge clk);
    in_valid = 1'b0; in_a = junk; in_b = ~junk;
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        checks++;
        if (q_prod.size() == 0) begin
          errors++;
          $display("FAIL R7: unexpected result %h at cycle %0d, expected none", out_product, cyc);
        end else begin
          logic [W-1:0] ep;
          int due;
          string tg;
          ep = q_prod.pop_front(); due = q_due.pop_front(); tg = q_tag.pop_front();
          if (out_product !== ep) begin
            errors++;
            $display("FAIL %s: product %h, expected %h", tg, out_product, ep);
          end
          checks++;
          if (due != cyc) begin
            errors++;
            $display("FAIL R3: result at cycle %0d, expected cycle %0d", cyc, due);
          end
        end
      end else if (q_due.size() != 0 && q_due[0] <= cyc) begin
        checks++;
        errors++;
        $display("FAIL R4: no result at cycle %0d, expected %h", cyc, q_prod[0]);
        void'(q_prod.pop_front()); void'(q_due.pop_front()); void'(q_tag.pop_front());
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R5: out_valid %b during reset, expected 0", out_valid);
    end
    rst = 1'b0;

    // R1 R4 R6: exhaustive, back to back
    for (int a = -32; a < 32; a++)
      for (int b = -32; b < 32; b++)
        drive(a[N-1:0], b[N-1:0], "R1");

    // R2: most negative operands
    drive(6'b100000, 6'b100000, "R2");
    drive(6'b100000, 6'b011111, "R2");
    drive(6'b011111, 6'b100000, "R2");
    drive(6'b100000, 6'b111111, "R2");

    // R6: multipliers of -2 and -1 digits
    drive(6'b011111, 6'b100100, "R6");
    drive(6'b100001, 6'b101101, "R6");
    drive(6'b000001, 6'b110110, "R6");

    // R7: gaps with junk on the operand pins
    idle(6'b101010);
    drive(6'b000111, 6'b111001, "R7");
    idle(6'b010101);
    idle(6'b111111);
    drive(6'b100000, 6'b000011, "R7");
    idle(6'b110011);
    repeat (S + 3) idle(6'b001100);

    // R5: reset with operands in flight
    drive(6'b010101, 6'b001011, "R5");
    drive(6'b001011, 6'b010101, "R5");
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    q_prod.delete(); q_due.delete(); q_tag.delete();
    repeat (2) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R5: out_valid %b after reset, expected 0", out_valid);
    end
    rst = 1'b0;
    repeat (S + 3) idle(6'b000000);
    drive(6'b111110, 6'b000010, "R5");
    repeat (S + 3) idle(6'b000000);

    checks++;
    if (q_prod.size() != 0) begin
      errors++;
      $display("FAIL R4: %0d results outstanding, expected 0", q_prod.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule